// File: doc/BRIEF.md
# Daisy-Chained Result Collection Array

A row of identical processing cells, each summing the samples that arrive on its own input lane. When the consumer asks for the totals with a one-cycle collect strobe, every cell copies its running sum into a hand-off register in the same cycle and restarts its sum. The hand-off registers then form a shift chain. Each cell talks only to its immediate neighbours, and the consumer sees only the cell at the far end of the row. No result bus from any cell reaches a shared selector. The totals drain towards the consumer one position per accepted transfer.

The consumer side is a valid/ready stream. A result leaves the chain only on a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, the chain holds still and the presented word and its tag stay unchanged. Each delivered total carries the number of the cell that produced it. Cells are numbered 0 to NUM_PE-1, and cell NUM_PE-1 is the one wired to the output. Sample lanes have no ready: a lane sample with its valid bit set is always taken in the cycle it is presented. `busy` is high while a drain is under way. A collect strobe that arrives while `busy` is high is dropped.

Top module: `result_chain`

## Requirements
- R1: While reset is applied and in the first cycle after it, `out_valid` and `busy` are low. All running sums are zero, so a collect as the very first operation delivers NUM_PE totals of zero.
- R2: Each cell adds its lane's `in_data` word (zero-extended) to its running sum on every cycle where its `in_valid` bit is high. The sum wraps modulo 2^ACC_W. Lanes with a low valid bit leave the sum unchanged.
- R3: A collect strobe seen while `busy` is low is accepted. In that cycle every cell captures its running sum, excluding that cycle's own lane sample. Each cell's sum then restarts from that cycle's lane sample if its valid bit is high, or from zero otherwise.
- R4: In the cycle after an accepted collect, `out_valid` rises. It stays high until exactly NUM_PE transfers have completed and falls in the cycle after the last transfer. With `out_ready` held high, this gives exactly NUM_PE consecutive valid cycles.
- R5: Results are delivered nearest cell first. The k-th transfer (k from 0) carries `out_index` = NUM_PE-1-k and `out_data` equal to the total that cell captured.
- R6: When `out_valid` is high and `out_ready` is low, `out_data` and `out_index` hold their values into the next cycle, and no result is lost or repeated.
- R7: A collect strobe while `busy` is high has no effect. The drain continues with the same totals and order, and the running sums keep accumulating rather than restarting.
- R8: `busy` equals `out_valid`: it is high from the cycle after an accepted collect until the cycle after the final transfer. A collect strobe in that following cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | NUM_PE | Per-lane sample valid, bit i for cell i |
| in_data | input | NUM_PE*DATA_W | Per-lane samples, cell i in bits [i*DATA_W +: DATA_W] |
| collect | input | 1 | One-cycle request to capture and drain all totals |
| busy | output | 1 | Drain in progress; collect ignored |
| out_valid | output | 1 | Result word available to the consumer |
| out_ready | input | 1 | Consumer accepts the word this cycle |
| out_data | output | ACC_W | Total from the cell named by out_index |
| out_index | output | IDX_W | Number of the cell that produced out_data |

## Verification
The assertions place no limits on `out_ready` or `collect`: either may take any value in any cycle. The checks rely only on reset being held for at least one clock and on inputs being known values from then on. The stimulus drives every input on the falling edge, away from the sampling edge. It stalls the consumer with irregular ready patterns and raises collect in the middle of a drain, so the stall-hold and dropped-collect properties are triggered and not just left idle.

// File: rtl/result_chain_pkg.sv
package result_chain_pkg;
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
  function automatic int cnt_bits(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/chain_cell.sv
module chain_cell #(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 16,
  parameter int IDX_W  = 2,
  parameter int MY_IDX = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              capture,
  input  logic              shift,
  input  logic [ACC_W-1:0]  up_res,
  input  logic [IDX_W-1:0]  up_tag,
  output logic [ACC_W-1:0]  res,
  output logic [IDX_W-1:0]  tag
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] smp_ext;

  assign smp_ext = ACC_W'(smp_data);

  // Running sum: restarts on capture, otherwise adds valid samples.
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (capture) begin
      acc_q <= smp_valid ? smp_ext : '0;
    end else if (smp_valid) begin
      acc_q <= acc_q + smp_ext;
    end
  end

  // Hand-off register: synchronous reset keeps it a discrete flop stage.
  always_ff @(posedge clk) begin
    if (rst) begin
      res <= '0;
      tag <= '0;
    end else if (capture) begin
      res <= acc_q;
      tag <= IDX_W'(MY_IDX);
    end else if (shift) begin
      res <= up_res;
      tag <= up_tag;
    end
  end
endmodule

// File: rtl/drain_ctrl.sv
module drain_ctrl #(
  parameter int NUM_PE = 4,
  parameter int CNT_W  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic collect,
  input  logic out_ready,
  output logic capture,
  output logic shift,
  output logic busy
);
  logic [CNT_W-1:0] left_q;

  assign busy    = (left_q != '0);
  assign capture = collect && !busy;
  assign shift   = busy && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
    end else if (capture) begin
      left_q <= CNT_W'(NUM_PE);
    end else if (shift) begin
      left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/result_chain.sv
module result_chain #(
  parameter int NUM_PE = 4,
  parameter int DATA_W = 8,
  parameter int ACC_W  = 16,
  localparam int IDX_W = result_chain_pkg::idx_bits(NUM_PE)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_PE-1:0]        in_valid,
  input  logic [NUM_PE*DATA_W-1:0] in_data,
  input  logic                     collect,
  output logic                     busy,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [ACC_W-1:0]         out_data,
  output logic [IDX_W-1:0]         out_index
);
  localparam int CNT_W = result_chain_pkg::cnt_bits(NUM_PE);

  logic capture, shift;
  logic [ACC_W-1:0] link_res [NUM_PE];
  logic [IDX_W-1:0] link_tag [NUM_PE];

  drain_ctrl #(.NUM_PE(NUM_PE), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .collect(collect), .out_ready(out_ready),
    .capture(capture), .shift(shift), .busy(busy)
  );

  for (genvar g = 0; g < NUM_PE; g++) begin : g_cell
    logic [ACC_W-1:0] up_res;
    logic [IDX_W-1:0] up_tag;
    if (g == 0) begin : g_head
      assign up_res = '0;
      assign up_tag = '0;
    end else begin : g_link
      assign up_res = link_res[g-1];
      assign up_tag = link_tag[g-1];
    end
    chain_cell #(.DATA_W(DATA_W), .ACC_W(ACC_W), .IDX_W(IDX_W), .MY_IDX(g)) u_cell (
      .clk(clk), .rst(rst),
      .smp_valid(in_valid[g]), .smp_data(in_data[g*DATA_W +: DATA_W]),
      .capture(capture), .shift(shift),
      .up_res(up_res), .up_tag(up_tag),
      .res(link_res[g]), .tag(link_tag[g])
    );
  end

  assign out_valid = busy;
  assign out_data  = link_res[NUM_PE-1];
  assign out_index = link_tag[NUM_PE-1];
endmodule

// File: rtl/result_chain_chk.sv
module result_chain_chk #(
  parameter int NUM_PE = 4,
  parameter int ACC_W  = 16,
  parameter int IDX_W  = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             collect,
  input logic             busy,
  input logic             out_valid,
  input logic             out_ready,
  input logic [ACC_W-1:0] out_data,
  input logic [IDX_W-1:0] out_index
);
  AST_COLLECT_OPENS: assert property (@(posedge clk) disable iff (rst)
    collect && !busy |=> out_valid && out_index == IDX_W'(NUM_PE-1)); // R4
  AST_INDEX_DESCENDS: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_index != '0 |=> out_valid && out_index == $past(out_index) - 1'b1); // R5
  AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_index == '0 |=> !out_valid); // R4
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_index)); // R6
  AST_BUSY_COLLECT_DROPPED: assert property (@(posedge clk) disable iff (rst)
    busy && collect && !out_ready |=> busy && $stable(out_index)); // R7
  AST_BUSY_MATCHES_VALID: assert property (@(posedge clk) disable iff (rst)
    busy == out_valid); // R8
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> !out_valid && !busy); // R1
endmodule

bind result_chain result_chain_chk #(.NUM_PE(NUM_PE), .ACC_W(ACC_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .collect(collect), .busy(busy), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_index(out_index)
);

// File: tb/tb_result_chain.sv
module tb_result_chain;
  localparam int N  = 4;
  localparam int DW = 8;
  localparam int AW = 16;
  localparam int IW = 2;

  logic clk = 0;
  logic rst = 1;
  logic [N-1:0]    in_valid = '0;
  logic [N*DW-1:0] in_data  = '0;
  logic collect = 0;
  logic out_ready = 0;
  logic busy, out_valid;
  logic [AW-1:0] out_data;
  logic [IW-1:0] out_index;

  int checks = 0;
  int fails  = 0;
  logic [AW-1:0] acc_m [N];
  logic [AW-1:0] cap_m [N];

  always #2 clk = ~clk;

  result_chain #(.NUM_PE(N), .DATA_W(DW), .ACC_W(AW)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .collect(collect),
    .busy(busy), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_index(out_index)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Present lane samples for one cycle (optionally with collect) and update the model.
  task automatic cycle(input logic [N-1:0] v, input logic [N*DW-1:0] d, input bit col);
    bit accept;
    accept = col && !busy;
    in_valid = v; in_data = d; collect = col;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      logic [AW-1:0] s;
      s = AW'(d[i*DW +: DW]);
      if (accept) begin
        cap_m[i] = acc_m[i];
        acc_m[i] = v[i] ? s : '0;
      end else if (v[i]) begin
        acc_m[i] = acc_m[i] + s;
      end
    end
    in_valid = '0; in_data = '0; collect = 0;
  endtask

  // Drain all results with a ready pattern; optionally strobe collect mid-drain.
  task automatic drain(input logic [31:0] pat, input bit mid_collect);
    int k = 0;
    for (int cyc = 0; cyc < 200 && k < N; cyc++) begin
      chk(out_valid === 1'b1, "R4 valid during drain", out_valid, 1);
      chk(busy === 1'b1, "R8 busy during drain", busy, 1);
      chk(out_index === IW'(N-1-k), "R5 index order", out_index, N-1-k);
      chk(out_data === cap_m[N-1-k], "R5 R6 delivered total", out_data, cap_m[N-1-k]);
      out_ready = pat[cyc % 32];
      if (pat[cyc % 32]) k++;
      if (mid_collect && cyc == 1) cycle('1, {8'd4, 8'd3, 8'd2, 8'd1}, 1'b1);
      else @(negedge clk);
    end
    out_ready = 0;
    chk(out_valid === 1'b0, "R4 valid falls after last transfer", out_valid, 0);
    chk(busy === 1'b0, "R8 busy falls after last transfer", busy, 0);
  endtask

  task automatic t_reset();
    chk(out_valid === 1'b0 && busy === 1'b0, "R1 idle after reset", {out_valid, busy}, 0);
    cycle('0, '0, 1'b1);
    drain('1, 1'b0); // all totals zero after reset (R1)
  endtask

  task automatic t_basic();
    cycle('1, {8'd40, 8'd30, 8'd20, 8'd10}, 1'b0);
    cycle(4'b0101, {8'd99, 8'd7, 8'd99, 8'd5}, 1'b0); // R2 lanes 1,3 ignored
    cycle(4'b1010, {8'd1, 8'd77, 8'd2, 8'd77}, 1'b0);
    cycle('1, {8'd9, 8'd9, 8'd9, 8'd9}, 1'b1); // R3 sample in collect cycle starts new round
    drain('1, 1'b0);
  endtask

  task automatic t_stall();
    cycle('1, {8'd11, 8'd22, 8'd33, 8'd44}, 1'b1);
    drain(32'hA5C3_0F91, 1'b0); // R6 irregular back-pressure
  endtask

  task automatic t_busy_collect();
    cycle('1, {8'd5, 8'd6, 8'd7, 8'd8}, 1'b1);
    drain(32'b1101, 1'b1); // R7 collect while busy dropped
    cycle('0, '0, 1'b1); // R8 collect right after drain accepted
    drain('1, 1'b0);     // totals include samples from drop cycle (R7)
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 300; i++) cycle(4'b0001, {24'd0, 8'hFF}, 1'b0);
    cycle('0, '0, 1'b1); // R2 wrap: 300*255 mod 65536
    chk(cap_m[0] === 16'd10964, "R2 model wrap", cap_m[0], 10964);
    drain('1, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin acc_m[i] = '0; cap_m[i] = '0; end
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R1 valid low in reset", out_valid, 0);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_stall();
    t_busy_collect();
    t_wrap();
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule